// File: doc/BRIEF.md
# Address Window Decoder with Remap

This block turns a CPU bus address into a target address on one of two PCI buses. Each bus owns five windows: one I/O window and four memory windows. Each of these ten windows has three registers: a start register, a length register and a 64-bit remap value. The remap value is split into a 16-bit low half and a 32-bit high half. An eleventh window covers the chip's own register space. It is fixed at 64 KB and has no remap. One shared enable register uses active-low bits to open or close every window.

Software programs the windows through a 32-bit register port. Register writes take effect on the clock edge and reads return data combinationally. The lookup path is purely combinational. For the CPU address presented, it reports whether an enabled window was hit, which window won, and the translated target address.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset, the enable register reads 0x1FFFFF and every window is closed, so no address hits. The config register and all window registers read 0.
- R2: Window numbering is index = bus*5 + kind, where kind 0 is the I/O window and kinds 1 to 4 are memory windows 0 to 3. Window i is open only while enable bit 9+i is 0, and the register window is open only while enable bit 20 is 0. The enable register keeps bits 20:0 only.
- R3: A window starts at its start register bits 19:0 shifted left by 16. A memory window's start register keeps only the bits under mask 0x070FFFFF. An I/O window's start register keeps only the bits under 0x030FFFFF.
- R4: A window spans (length register bits 15:0 + 1) x 64 KB. An address hits when start <= address < start + span. The length register reads back its low 16 bits only.
- R5: On a hit, the target address is remap + (address - start), computed in 64 bits.
- R6: A write to the remap-low register puts data bits 15:0 into remap bits 31:16 and leaves remap bits 63:32 unchanged. A read of remap-low returns remap bits 31:16 in data bits 15:0.
- R7: A write to the remap-high register replaces remap bits 63:32. A read returns those bits.
- R8: While config bit 27 is 0, a start-register write also copies data bits 15:0 into remap bits 31:16. While config bit 27 is 1, that write leaves the remap unchanged.
- R9: When several open windows contain the address, the lowest index wins. The register window has index 10.
- R10: On a miss, hit is 0, the index is 0 and the target address is 0.
- R11: The register window's start register (address 50) keeps bits 19:0. The window spans 64 KB, and its target address is the offset into the window.
- R12: A register write changes lookups only from the following cycle, so a lookup in the write cycle uses the old values. Register addresses are laid out as follows:
  - window w, field f: address 4*w + f, with f = 0 start, 1 length, 2 remap-low, 3 remap-high;
  - config: address 48;
  - enable: address 49.
  Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| cpu_addr | input | 36 | CPU address to translate |
| hit | output | 1 | An open window contains cpu_addr |
| win_idx | output | 4 | Index of the winning window |
| tgt_addr | output | 64 | Translated target address |

## Verification
A register write and a lookup can fall in the same cycle. The bench provokes this by presenting an address inside the register window while, in that same cycle, it writes the enable bit that closes the window. The lookup is sampled twice. Before the edge it must still report a hit. After the edge it must report a miss. A second case checks the same rule for a start-register write made while the remap lock is set: the copy into the remap must be suppressed, and the translated address must be unchanged in both cycles.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
    localparam int NUM_BUS     = 2;
    localparam int WIN_PER_BUS = 5;
    localparam int NUM_WIN     = NUM_BUS * WIN_PER_BUS;
    localparam int NUM_SLOT    = NUM_WIN + 1;
    localparam int IDX_W       = $clog2(NUM_SLOT);
    localparam int CPU_W       = 36;
    localparam int TGT_W       = 64;
    localparam int GRAN        = 16;
    localparam int BASE_W      = CPU_W - GRAN;
    localparam int SIZE_W      = 16;
    localparam int SPAN_W      = SIZE_W + GRAN + 1;
    localparam int EN_W        = 21;
    localparam int EN_LSB      = 9;
    localparam int EN_REGWIN   = 20;
    localparam int LOCK_BIT    = 27;
    localparam int REG_AW      = 6;

    localparam logic [REG_AW-1:0] A_CFG    = 6'd48;
    localparam logic [REG_AW-1:0] A_ENABLE = 6'd49;
    localparam logic [REG_AW-1:0] A_REGWIN = 6'd50;

    typedef enum logic [1:0] {
        F_START    = 2'd0,
        F_LENGTH   = 2'd1,
        F_REMAP_LO = 2'd2,
        F_REMAP_HI = 2'd3
    } field_e;

    typedef struct packed {
        logic              open;
        logic [BASE_W-1:0] start;
        logic [SIZE_W-1:0] length;
        logic [TGT_W-1:0]  remap;
    } win_cfg_t;

    function automatic logic [31:0] start_mask(input int kind);
        return (kind == 0) ? 32'h030F_FFFF : 32'h070F_FFFF;
    endfunction
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output win_cfg_t [NUM_SLOT-1:0]    cfg_o
);
    logic [31:0]     start_q [NUM_WIN];
    logic [SIZE_W-1:0] len_q [NUM_WIN];
    logic [15:0]     rlo_q   [NUM_WIN];
    logic [31:0]     rhi_q   [NUM_WIN];
    logic [31:0]     conf_q;
    logic [EN_W-1:0] en_q;
    logic [BASE_W-1:0] regwin_q;

    field_e fsel;
    assign fsel = field_e'(reg_addr[1:0]);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int KIND = w % WIN_PER_BUS;
        logic sel;
        assign sel = wr_en && (reg_addr[REG_AW-1:2] == 4'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                start_q[w] <= '0;
                len_q[w]   <= '0;
                rlo_q[w]   <= '0;
                rhi_q[w]   <= '0;
            end else if (sel) begin
                unique case (fsel)
                    F_START: begin
                        start_q[w] <= wdata & start_mask(KIND);
                        if (!conf_q[LOCK_BIT]) rlo_q[w] <= wdata[15:0];
                    end
                    F_LENGTH:   len_q[w] <= wdata[SIZE_W-1:0];
                    F_REMAP_LO: rlo_q[w] <= wdata[15:0];
                    F_REMAP_HI: rhi_q[w] <= wdata;
                endcase
            end
        end

        assign cfg_o[w].open   = ~en_q[EN_LSB + w];
        assign cfg_o[w].start  = start_q[w][BASE_W-1:0];
        assign cfg_o[w].length = len_q[w];
        assign cfg_o[w].remap  = {rhi_q[w], rlo_q[w], 16'h0000};

        AST_REMAP_HI_KEEP: assert property (@(posedge clk) disable iff (rst)
            (sel && fsel == F_REMAP_LO) |=> $stable(rhi_q[w])); // R6
        AST_REMAP_LOCKED: assert property (@(posedge clk) disable iff (rst)
            (sel && fsel == F_START && conf_q[LOCK_BIT]) |=> $stable(rlo_q[w])); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conf_q   <= '0;
            en_q     <= '1;
            regwin_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_CFG)    conf_q   <= wdata;
            if (reg_addr == A_ENABLE) en_q     <= wdata[EN_W-1:0];
            if (reg_addr == A_REGWIN) regwin_q <= wdata[BASE_W-1:0];
        end
    end

    assign cfg_o[NUM_WIN].open   = ~en_q[EN_REGWIN];
    assign cfg_o[NUM_WIN].start  = regwin_q;
    assign cfg_o[NUM_WIN].length = '0;
    assign cfg_o[NUM_WIN].remap  = '0;

    logic [3:0] widx;
    assign widx = reg_addr[REG_AW-1:2];

    always_comb begin
        rdata = '0;
        if (widx < 4'(NUM_WIN)) begin
            unique case (fsel)
                F_START:    rdata = start_q[widx];
                F_LENGTH:   rdata = 32'(len_q[widx]);
                F_REMAP_LO: rdata = {16'h0000, rlo_q[widx]};
                F_REMAP_HI: rdata = rhi_q[widx];
            endcase
        end else if (reg_addr == A_CFG) begin
            rdata = conf_q;
        end else if (reg_addr == A_ENABLE) begin
            rdata = 32'(en_q);
        end else if (reg_addr == A_REGWIN) begin
            rdata = 32'(regwin_q);
        end
    end

    AST_EN_RESET_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == {EN_W{1'b1}})); // R1
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [CPU_W-1:0]  cpu_addr,
    output logic              hit,
    output logic [TGT_W-1:0]  tgt
);
    logic [CPU_W-1:0]  first;
    logic [CPU_W-1:0]  offset;
    logic [SPAN_W-1:0] span;

    assign first  = {cfg.start, {GRAN{1'b0}}};
    assign offset = cpu_addr - first;
    assign span   = {({1'b0, cfg.length} + 17'd1), {GRAN{1'b0}}};
    assign hit    = cfg.open && (cpu_addr >= first) &&
                    (offset < CPU_W'(span));
    assign tgt    = cfg.remap + TGT_W'(offset);
endmodule

// File: rtl/addrwin_prio.sv
module addrwin_prio
    import addrwin_pkg::*;
(
    input  logic [NUM_SLOT-1:0]             hit_vec,
    input  logic [NUM_SLOT-1:0][TGT_W-1:0]  tgt_vec,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx,
    output logic [TGT_W-1:0]                tgt
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        tgt = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
                tgt = tgt_vec[i];
            end
        end
    end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
    import addrwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [35:0]       cpu_addr,
    output logic              hit,
    output logic [3:0]        win_idx,
    output logic [63:0]       tgt_addr
);
    win_cfg_t [NUM_SLOT-1:0]            slot_cfg;
    logic [NUM_SLOT-1:0]                hit_vec;
    logic [NUM_SLOT-1:0][TGT_W-1:0]     tgt_vec;

    addrwin_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .cfg_o    (slot_cfg)
    );

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_match
        addrwin_match u_match (
            .cfg      (slot_cfg[s]),
            .cpu_addr (cpu_addr),
            .hit      (hit_vec[s]),
            .tgt      (tgt_vec[s])
        );
    end

    addrwin_prio u_prio (
        .hit_vec (hit_vec),
        .tgt_vec (tgt_vec),
        .hit     (hit),
        .idx     (win_idx),
        .tgt     (tgt_addr)
    );

    AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        hit |-> slot_cfg[win_idx].open); // R2
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (win_idx < 4'(NUM_SLOT))); // R9
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((hit_vec & ((NUM_SLOT'(1) << win_idx) - NUM_SLOT'(1))) == '0)); // R9
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hit_vec == '0) |-> (!hit && win_idx == '0 && tgt_addr == '0)); // R10
endmodule

// File: tb/addrwin_decoder_test.sv
module addrwin_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [35:0] cpu_addr = '0;
    logic        hit;
    logic [3:0]  win_idx;
    logic [63:0] tgt_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    addrwin_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wdata(wdata), .rdata(rdata), .cpu_addr(cpu_addr),
        .hit(hit), .win_idx(win_idx), .tgt_addr(tgt_addr)
    );

    // {cpu_addr, exp_hit, exp_idx, exp_tgt}
    localparam int NV = 11;
    localparam logic [104:0] VEC [NV] = '{
        {36'h0_0100_0000, 1'b1, 4'd0,  64'h0000_0000_2000_0000},  // R5
        {36'h0_010F_FFFF, 1'b1, 4'd0,  64'h0000_0000_200F_FFFF},  // R4 top edge
        {36'h0_0110_0000, 1'b0, 4'd0,  64'h0},                    // R4 past end
        {36'h0_00FF_FFFF, 1'b0, 4'd0,  64'h0},                    // R3 below start
        {36'h0_0200_8000, 1'b1, 4'd1,  64'h0000_0001_0200_8000},  // R9 overlap
        {36'h0_0201_0000, 1'b1, 4'd2,  64'h0000_0000_5001_0000},  // R9 second window
        {36'h0_0202_0000, 1'b0, 4'd0,  64'h0},                    // R10
        {36'h0_0030_1234, 1'b1, 4'd10, 64'h0000_0000_0000_1234},  // R11
        {36'hF_FFFF_0010, 1'b1, 4'd9,  64'h0000_0000_FFFF_0010},  // R3 top start
        {36'hF_FFFF_FFFF, 1'b1, 4'd9,  64'h0000_0000_FFFF_FFFF},  // R4
        {36'h0_0000_0000, 1'b0, 4'd0,  64'h0}                     // R2 closed
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = rdata;
    endtask

    task automatic look(input logic [35:0] a);
        @(negedge clk);
        cpu_addr = a;
        #2;
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        rd(6'd49, d); chk("R1 enable reset", 64'(d), 64'h1F_FFFF);
        rd(6'd48, d); chk("R1 config reset", 64'(d), 64'h0);
        rd(6'd0, d);  chk("R1 start reset", 64'(d), 64'h0);
        look(36'h0); chk("R1 no hit", 64'(hit), 64'h0);

        wr(6'd0, 32'h0000_0100);      // window 0 (bus0 I/O)
        rd(6'd2, d); chk("R8 copy on start write", 64'(d), 64'h0100);
        wr(6'd2, 32'h0000_2000);
        wr(6'd1, 32'h0000_000F);
        wr(6'd7, 32'h0000_0001);      // window 1 remap high
        wr(6'd4, 32'h0000_0200);
        wr(6'd8, 32'h0000_0200);      // window 2
        wr(6'd9, 32'h0000_0001);
        wr(6'd10, 32'h0000_5000);
        wr(6'd36, 32'h000F_FFFF);     // window 9 (bus1 mem3)
        wr(6'd50, 32'h0000_0030);     // register window
        wr(6'd49, 32'h000B_F1FF);     // open 0,1,2,9 and register window

        for (int i = 0; i < NV; i++) begin
            look(VEC[i][104:69]);
            chk("R5/R9 table hit", 64'(hit), 64'(VEC[i][68]));
            chk("R9 table idx", 64'(win_idx), 64'(VEC[i][67:64]));
            chk("R5 table tgt", tgt_addr, VEC[i][63:0]);
        end

        // R3 / R4 masks on closed windows
        wr(6'd12, 32'hFFFF_FFFF);
        rd(6'd12, d); chk("R3 mem mask", 64'(d), 64'h070F_FFFF);
        wr(6'd20, 32'hFFFF_FFFF);
        rd(6'd20, d); chk("R3 io mask", 64'(d), 64'h030F_FFFF);
        wr(6'd13, 32'hFFFF_FFFF);
        rd(6'd13, d); chk("R4 length mask", 64'(d), 64'hFFFF);
        rd(6'd2, d); chk("R6 remap lo read", 64'(d), 64'h2000);
        rd(6'd7, d); chk("R7 remap hi read", 64'(d), 64'h1);

        // R7 then R6: high kept across low write
        wr(6'd39, 32'hABCD_0000);
        wr(6'd38, 32'h0000_1111);
        rd(6'd39, d); chk("R6 hi unchanged", 64'(d), 64'hABCD_0000);
        look(36'hF_FFFF_0010);
        chk("R7 tgt with hi", tgt_addr, 64'hABCD_0000_1111_0010);

        // R8 lock, with same-cycle lookup (R12)
        wr(6'd48, 32'h0800_0000);
        @(negedge clk);
        cpu_addr = 36'h0_0100_0010;
        wr_en = 1'b1; reg_addr = 6'd0; wdata = 32'h0000_0100;
        #2 chk("R12 same cycle tgt", tgt_addr, 64'h2000_0010);
        @(posedge clk); #1 wr_en = 1'b0;
        #2 chk("R8 locked tgt", tgt_addr, 64'h2000_0010);
        rd(6'd2, d); chk("R8 locked remap", 64'(d), 64'h2000);
        wr(6'd48, 32'h0);
        wr(6'd0, 32'h0000_0100);
        rd(6'd2, d); chk("R8 unlocked copy", 64'(d), 64'h0100);

        // R12: closing window in the cycle of a lookup
        @(negedge clk);
        cpu_addr = 36'h0_0030_1234;
        wr_en = 1'b1; reg_addr = 6'd49; wdata = 32'h001B_F1FF;
        #2 chk("R12 old enable used", 64'(hit), 64'h1);
        @(posedge clk); #1 wr_en = 1'b0;
        #2 chk("R12 new enable used", 64'(hit), 64'h0);
        rd(6'd49, d); chk("R2 enable width", 64'(d), 64'h1B_F1FF);

        // R12 unmapped
        wr(6'd60, 32'hFFFF_FFFF);
        rd(6'd60, d); chk("R12 unmapped read", 64'(d), 64'h0);
        rd(6'd49, d); chk("R12 unmapped write ignored", 64'(d), 64'h1B_F1FF);
        look(36'h0_0200_0004);
        chk("R12 lookup after unmapped write", tgt_addr, 64'h0000_0001_0200_0004);

        // R11 register window start width
        wr(6'd50, 32'hFFFF_FFFF);
        rd(6'd50, d); chk("R11 start width", 64'(d), 64'hF_FFFF);
        wr(6'd49, 32'h000F_FFFF);
        look(36'hF_FFFF_0020);
        chk("R11 reg window idx", 64'(win_idx), 64'd10);
        chk("R11 reg window tgt", tgt_addr, 64'h20);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule